// File: doc/BRIEF.md
# Exception Context Save and Return Controller

This block sits beside the pipeline of a small CPU core with delayed branches and owns the status register, the saved return address and the saved status. When the pipeline reports an exception or interrupt, the controller picks the address at which execution must resume. That choice depends on whether the event re-executes the faulting instruction or completes it, and on whether the instruction sits in a delay slot or is itself a delayed branch. In the same clock edge the controller copies the status register into the saved status, sets the block bit and raises an entry request. The entry request stays high until the handler-side logic acknowledges it.

A return command restores the status register from the saved status and issues a one-cycle branch request to the saved return address. A return that arrives while an entry is under way is remembered and carried out once the entry has been acknowledged. A general exception that arrives while the block bit is already set is not taken as an entry. It becomes a forced manual reset instead, with a fixed event code and a redirect to the reset vector. An interrupt or user break that arrives with the block bit set is not accepted.

Top module: `exc_ctx_ctrl`

## Requirements
- R1: While reset is high: branch request is 1, branch PC is RESET_VEC (default 0xA0000000), status is only the block bit (bit BL_BIT, default 28), entry request and manual-reset pulse are 0, saved PC is 0. The branch request falls on the first edge after reset is released.
- R2: An accepted kind-0 (re-execute) exception whose instruction is not in a delay slot saves the current PC.
- R3: An accepted kind-0 exception on a delay-slot instruction saves the delay-slot PC, regardless of the delayed-branch flag.
- R4: An accepted kind-1 (completion), kind-2 (interrupt) or kind-3 (user break) event saves the branch target when the delayed-branch flag is set, and the next PC otherwise.
- R5: On the edge that accepts an entry, saved status takes the old status, status gains the block bit and event code takes the request's code. Entry request is high from the next cycle until the cycle after acknowledge.
- R6: A kind-0 or kind-1 request while the block bit is 1 gives a one-cycle manual-reset pulse, event code 0x20, a branch request to RESET_VEC, and no entry. Saved PC and saved status keep their values.
- R7: A kind-2 or kind-3 request while the block bit is 1 changes nothing: no entry, no pulse, no branch, and saved PC, event code and status are unchanged.
- R8: An exception request while entry request is high is ignored; the saved PC is unchanged.
- R9: A return command while idle gives, one cycle later, a one-cycle branch request to the saved PC, with status restored from saved status.
- R10: A return command that arrives in the accepting cycle or while entry request is high gives no branch until entry completes. It is then carried out on the second edge after the acknowledge edge.
- R11: A software status write lands on the next edge unless an entry, manual reset or return happens on that edge, in which case the write is dropped.
- R12: The link-write suppress output is high, in the same cycle, exactly when a kind-0 delay-slot request is being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception or interrupt request |
| exc_kind | input | 2 | 0 re-execute, 1 completion, 2 interrupt, 3 user break |
| exc_code | input | EW | Event code stored on entry |
| in_dslot | input | 1 | Faulting instruction is in a delay slot |
| on_dbranch | input | 1 | Faulting instruction is a delayed branch |
| cur_pc | input | PW | PC of the faulting instruction |
| next_pc | input | PW | PC of the following instruction |
| slot_pc | input | PW | PC of the delay-slot instruction |
| br_target | input | PW | Target of the delayed branch |
| sr_wr | input | 1 | Software status write enable |
| sr_wdata | input | SRW | Software status write data |
| rte_req | input | 1 | Return-from-exception command |
| ent_ack | input | 1 | Entry acknowledge |
| ent_req | output | 1 | Entry request, held until acknowledged |
| link_inhibit | output | 1 | Suppress the call link-register write |
| mrst_pulse | output | 1 | Forced manual-reset pulse |
| br_req | output | 1 | Branch request |
| br_pc | output | PW | Branch destination |
| sr_q | output | SRW | Status register |
| spc_q | output | PW | Saved return PC |
| ssr_q | output | SRW | Saved status |
| evt_q | output | EW | Event code |

## Verification
Entry and return can meet in one cycle. This happens either when the return command comes in the cycle an exception is accepted, or when it comes while the entry request is still waiting for acknowledge. The bench provokes both. It checks that no branch appears until the entry finishes, and that the later branch goes to the address just saved with the status just saved. A software status write placed in the same cycle as an accepted entry is also driven, and only the entry's status update must remain.

// File: rtl/exc_ctx_pkg.sv
package exc_ctx_pkg;

  typedef enum logic [1:0] {
    EK_REEXEC   = 2'b00,
    EK_COMPLETE = 2'b01,
    EK_INTR     = 2'b10,
    EK_UBRK     = 2'b11
  } exc_kind_e;

  typedef enum logic [1:0] {
    RS_CUR  = 2'd0,
    RS_SLOT = 2'd1,
    RS_NEXT = 2'd2,
    RS_TGT  = 2'd3
  } ret_src_e;

  // General exceptions are the ones that escalate to a manual reset.
  function automatic logic is_general(exc_kind_e k);
    return (k == EK_REEXEC) || (k == EK_COMPLETE);
  endfunction

  // Which address the handler returns to.
  function automatic ret_src_e ret_src(exc_kind_e k, logic ds, logic db);
    if (k == EK_REEXEC) return ds ? RS_SLOT : RS_CUR;
    return db ? RS_TGT : RS_NEXT;
  endfunction

endpackage

// File: rtl/exc_ret_pc_sel.sv
module exc_ret_pc_sel
  import exc_ctx_pkg::*;
#(
  parameter int PW = 32
) (
  input  exc_kind_e         kind,
  input  logic              ds,
  input  logic              db,
  input  logic [PW-1:0]     cur_pc,
  input  logic [PW-1:0]     next_pc,
  input  logic [PW-1:0]     slot_pc,
  input  logic [PW-1:0]     tgt_pc,
  output logic [PW-1:0]     ret_pc
);

  ret_src_e src;

  always_comb begin
    src = ret_src(kind, ds, db);
    unique case (src)
      RS_CUR:  ret_pc = cur_pc;
      RS_SLOT: ret_pc = slot_pc;
      RS_NEXT: ret_pc = next_pc;
      default: ret_pc = tgt_pc;
    endcase
  end

endmodule

// File: rtl/exc_accept.sv
module exc_accept
  import exc_ctx_pkg::*;
(
  input  logic      req,
  input  exc_kind_e kind,
  input  logic      ds,
  input  logic      busy,
  input  logic      bl,
  output logic      take,
  output logic      mrst,
  output logic      link_inh
);

  logic live;

  always_comb begin
    live     = req && !busy;
    take     = live && !bl;
    mrst     = live && bl && is_general(kind);
    link_inh = take && (kind == EK_REEXEC) && ds;
  end

endmodule

// File: rtl/exc_ctx_ctrl.sv
module exc_ctx_ctrl
  import exc_ctx_pkg::*;
#(
  parameter int          PW        = 32,
  parameter int          SRW       = 32,
  parameter int          EW        = 32,
  parameter int          BL_BIT    = 28,
  parameter logic [PW-1:0] RESET_VEC = 32'hA000_0000,
  parameter logic [EW-1:0] MRST_CODE = 32'h0000_0020
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_req,
  input  logic [1:0]      exc_kind,
  input  logic [EW-1:0]   exc_code,
  input  logic            in_dslot,
  input  logic            on_dbranch,
  input  logic [PW-1:0]   cur_pc,
  input  logic [PW-1:0]   next_pc,
  input  logic [PW-1:0]   slot_pc,
  input  logic [PW-1:0]   br_target,
  input  logic            sr_wr,
  input  logic [SRW-1:0]  sr_wdata,
  input  logic            rte_req,
  input  logic            ent_ack,
  output logic            ent_req,
  output logic            link_inhibit,
  output logic            mrst_pulse,
  output logic            br_req,
  output logic [PW-1:0]   br_pc,
  output logic [SRW-1:0]  sr_q,
  output logic [PW-1:0]   spc_q,
  output logic [SRW-1:0]  ssr_q,
  output logic [EW-1:0]   evt_q
);

  localparam logic [SRW-1:0] BL_MASK = SRW'(1) << BL_BIT;

  exc_kind_e     kind;
  logic          busy;
  logic          rte_pend;
  logic          take_w;
  logic          mrst_w;
  logic          ret_go_w;
  logic [PW-1:0] ret_pc_w;

  assign kind = exc_kind_e'(exc_kind);

  exc_accept u_acc (
    .req      (exc_req),
    .kind     (kind),
    .ds       (in_dslot),
    .busy     (busy),
    .bl       (sr_q[BL_BIT]),
    .take     (take_w),
    .mrst     (mrst_w),
    .link_inh (link_inhibit)
  );

  exc_ret_pc_sel #(.PW(PW)) u_sel (
    .kind    (kind),
    .ds      (in_dslot),
    .db      (on_dbranch),
    .cur_pc  (cur_pc),
    .next_pc (next_pc),
    .slot_pc (slot_pc),
    .tgt_pc  (br_target),
    .ret_pc  (ret_pc_w)
  );

  // A return runs only when no entry is pending or starting.
  assign ret_go_w = (rte_req || rte_pend) && !busy && !take_w && !mrst_w;
  assign ent_req  = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      rte_pend   <= 1'b0;
      sr_q       <= BL_MASK;
      spc_q      <= '0;
      ssr_q      <= '0;
      evt_q      <= '0;
      br_req     <= 1'b1;
      br_pc      <= RESET_VEC;
      mrst_pulse <= 1'b0;
    end else begin
      br_req     <= 1'b0;
      mrst_pulse <= mrst_w;

      if (ret_go_w)     rte_pend <= 1'b0;
      else if (rte_req) rte_pend <= 1'b1;

      if (busy && ent_ack) busy <= 1'b0;

      if (take_w) begin
        spc_q <= ret_pc_w;
        ssr_q <= sr_q;
        sr_q  <= sr_q | BL_MASK;
        evt_q <= exc_code;
        busy  <= 1'b1;
      end else if (mrst_w) begin
        evt_q  <= MRST_CODE;
        sr_q   <= sr_q | BL_MASK;
        br_req <= 1'b1;
        br_pc  <= RESET_VEC;
      end else if (ret_go_w) begin
        sr_q   <= ssr_q;
        br_req <= 1'b1;
        br_pc  <= spc_q;
      end else if (sr_wr) begin
        sr_q <= sr_wdata;
      end
    end
  end

endmodule

// File: rtl/exc_ctx_chk.sv
module exc_ctx_chk #(
  parameter int            PW        = 32,
  parameter int            SRW       = 32,
  parameter int            EW        = 32,
  parameter int            BL_BIT    = 28,
  parameter logic [PW-1:0] RESET_VEC = 32'hA000_0000,
  parameter logic [EW-1:0] MRST_CODE = 32'h0000_0020
) (
  input logic           clk,
  input logic           rst,
  input logic           exc_req,
  input logic [1:0]     exc_kind,
  input logic [PW-1:0]  slot_pc,
  input logic           rte_req,
  input logic           ent_req,
  input logic           link_inhibit,
  input logic           mrst_pulse,
  input logic           br_req,
  input logic [PW-1:0]  br_pc,
  input logic [SRW-1:0] sr_q,
  input logic [PW-1:0]  spc_q,
  input logic [SRW-1:0] ssr_q,
  input logic [EW-1:0]  evt_q,
  input logic           take_w,
  input logic           mrst_w,
  input logic           ret_go_w
);

  a_r5_entry_sets_bl: assert property (@(posedge clk) disable iff (rst)
    take_w |=> sr_q[BL_BIT] && ent_req && ssr_q == $past(sr_q));

  a_r3_slot_saved: assert property (@(posedge clk) disable iff (rst)
    link_inhibit |=> spc_q == $past(slot_pc));

  a_r6_manual_reset: assert property (@(posedge clk) disable iff (rst)
    mrst_w |=> mrst_pulse && evt_q == MRST_CODE && br_req && br_pc == RESET_VEC
               && spc_q == $past(spc_q) && ssr_q == $past(ssr_q) && !ent_req);

  a_r7_blocked_ignored: assert property (@(posedge clk) disable iff (rst)
    exc_req && !ent_req && sr_q[BL_BIT] && exc_kind[1]
      |=> !ent_req && !mrst_pulse && !br_req && spc_q == $past(spc_q));

  a_r9_return: assert property (@(posedge clk) disable iff (rst)
    ret_go_w |=> br_req && br_pc == $past(spc_q) && sr_q == $past(ssr_q));

  a_r10_held_return: assert property (@(posedge clk) disable iff (rst)
    ent_req && rte_req |=> !br_req);

  a_r8_single_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_w, mrst_w, ret_go_w}));

endmodule

bind exc_ctx_ctrl exc_ctx_chk #(
  .PW(PW), .SRW(SRW), .EW(EW), .BL_BIT(BL_BIT),
  .RESET_VEC(RESET_VEC), .MRST_CODE(MRST_CODE)
) u_chk (
  .clk(clk), .rst(rst), .exc_req(exc_req), .exc_kind(exc_kind),
  .slot_pc(slot_pc), .rte_req(rte_req), .ent_req(ent_req),
  .link_inhibit(link_inhibit), .mrst_pulse(mrst_pulse), .br_req(br_req),
  .br_pc(br_pc), .sr_q(sr_q), .spc_q(spc_q), .ssr_q(ssr_q), .evt_q(evt_q),
  .take_w(take_w), .mrst_w(mrst_w), .ret_go_w(ret_go_w)
);

// File: tb/sim_exc_ctx_ctrl.sv
module sim_exc_ctx_ctrl;

  localparam logic [31:0] RV  = 32'hA000_0000;
  localparam logic [31:0] BLM = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req = 1'b0;
  logic [1:0]  exc_kind = 2'b00;
  logic [31:0] exc_code = '0;
  logic        in_dslot = 1'b0;
  logic        on_dbranch = 1'b0;
  logic [31:0] cur_pc = '0, next_pc = '0, slot_pc = '0, br_target = '0;
  logic        sr_wr = 1'b0;
  logic [31:0] sr_wdata = '0;
  logic        rte_req = 1'b0;
  logic        ent_ack = 1'b0;
  logic        ent_req, link_inhibit, mrst_pulse, br_req;
  logic [31:0] br_pc, sr_q, spc_q, ssr_q, evt_q;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] exp_spc, exp_ssr, exp_evt;

  always #5 clk = ~clk;

  exc_ctx_ctrl u0 (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_kind(exc_kind),
    .exc_code(exc_code), .in_dslot(in_dslot), .on_dbranch(on_dbranch),
    .cur_pc(cur_pc), .next_pc(next_pc), .slot_pc(slot_pc),
    .br_target(br_target), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .rte_req(rte_req), .ent_ack(ent_ack), .ent_req(ent_req),
    .link_inhibit(link_inhibit), .mrst_pulse(mrst_pulse), .br_req(br_req),
    .br_pc(br_pc), .sr_q(sr_q), .spc_q(spc_q), .ssr_q(ssr_q), .evt_q(evt_q)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 br_req", 32'(br_req), 1);
    chk("R1 br_pc", br_pc, RV);
    chk("R1 sr", sr_q, BLM);
    chk("R1 ent_req", 32'(ent_req), 0);
    chk("R1 mrst", 32'(mrst_pulse), 0);
    chk("R1 spc", spc_q, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 br_req falls", 32'(br_req), 0);
    exp_spc = 0; exp_ssr = 0; exp_evt = 0;

    for (int i = 0; i < 32; i++) begin
      logic [1:0]  k;
      logic        ds, db, bl;
      logic [31:0] srv, ret;
      k = i[4:3]; ds = i[2]; db = i[1]; bl = i[0];
      srv = 32'h0000_0F00 | i | (bl ? BLM : 32'h0);
      sr_wr = 1'b1; sr_wdata = srv;
      @(negedge clk);
      sr_wr = 1'b0;
      chk("R11 sw write", sr_q, srv);

      cur_pc = 32'h1000 + i * 16; next_pc = cur_pc + 2;
      slot_pc = 32'h2000 + i * 16; br_target = 32'h3000 + i * 16;
      exc_code = 32'h100 + i;
      exc_kind = k; in_dslot = ds; on_dbranch = db; exc_req = 1'b1;
      #1;
      chk("R12 link_inhibit", 32'(link_inhibit),
          32'((k == 2'd0) && ds && !bl));
      if (k == 2'd0) ret = ds ? slot_pc : cur_pc;
      else           ret = db ? br_target : next_pc;
      @(negedge clk);
      exc_req = 1'b0;

      if (bl && !k[1]) begin
        chk("R6 pulse", 32'(mrst_pulse), 1);
        chk("R6 code", evt_q, 32'h20);
        chk("R6 br_req", 32'(br_req), 1);
        chk("R6 br_pc", br_pc, RV);
        chk("R6 spc kept", spc_q, exp_spc);
        chk("R6 ssr kept", ssr_q, exp_ssr);
        chk("R6 no entry", 32'(ent_req), 0);
        exp_evt = 32'h20;
        @(negedge clk);
        chk("R6 one cycle", 32'(mrst_pulse | br_req), 0);
      end else if (bl) begin
        chk("R7 no entry", 32'(ent_req | mrst_pulse | br_req), 0);
        chk("R7 spc kept", spc_q, exp_spc);
        chk("R7 evt kept", evt_q, exp_evt);
        chk("R7 sr kept", sr_q, srv);
      end else begin
        if (k == 2'd0 && !ds) chk("R2 saved pc", spc_q, ret);
        else if (k == 2'd0)   chk("R3 saved pc", spc_q, ret);
        else                  chk("R4 saved pc", spc_q, ret);
        chk("R5 ssr", ssr_q, srv);
        chk("R5 sr bl", sr_q, srv | BLM);
        chk("R5 evt", evt_q, exc_code);
        chk("R5 ent_req", 32'(ent_req), 1);
        exp_spc = ret; exp_ssr = srv; exp_evt = exc_code;
        // second request and a return while the entry is pending
        exc_req = 1'b1; exc_kind = 2'b00; in_dslot = 1'b0; cur_pc = 32'hDEAD0;
        rte_req = 1'b1;
        @(negedge clk);
        exc_req = 1'b0; rte_req = 1'b0;
        chk("R8 spc kept", spc_q, exp_spc);
        chk("R8 still busy", 32'(ent_req), 1);
        chk("R10 no branch", 32'(br_req), 0);
        ent_ack = 1'b1;
        @(negedge clk);
        ent_ack = 1'b0;
        chk("R5 ack clears", 32'(ent_req), 0);
        chk("R10 not yet", 32'(br_req), 0);
        @(negedge clk);
        chk("R10 branch", 32'(br_req), 1);
        chk("R10 br_pc", br_pc, exp_spc);
        chk("R10 sr restored", sr_q, exp_ssr);
        @(negedge clk);
        chk("R9 one cycle", 32'(br_req), 0);
      end
    end

    // idle return
    rte_req = 1'b1;
    @(negedge clk);
    rte_req = 1'b0;
    chk("R9 branch", 32'(br_req), 1);
    chk("R9 br_pc", br_pc, exp_spc);
    chk("R9 sr", sr_q, exp_ssr);

    // entry, return and software write in the same cycle
    sr_wr = 1'b1; sr_wdata = 32'h55;
    @(negedge clk);
    exc_req = 1'b1; exc_kind = 2'b01; on_dbranch = 1'b0; in_dslot = 1'b0;
    next_pc = 32'h7770; exc_code = 32'h3C0;
    rte_req = 1'b1; sr_wr = 1'b1; sr_wdata = 32'hAAAA;
    @(negedge clk);
    exc_req = 1'b0; rte_req = 1'b0; sr_wr = 1'b0;
    chk("R11 write dropped", sr_q, 32'h55 | BLM);
    chk("R10 same cycle no branch", 32'(br_req), 0);
    chk("R4 saved next", spc_q, 32'h7770);
    ent_ack = 1'b1;
    @(negedge clk);
    ent_ack = 1'b0;
    chk("R10 waits", 32'(br_req), 0);
    @(negedge clk);
    chk("R10 late branch", 32'(br_req), 1);
    chk("R10 late pc", br_pc, 32'h7770);
    chk("R10 late sr", sr_q, 32'h55);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule